// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns characters into asynchronous serial frames on a single output line. Characters come from an upstream queue through a valid/pop interface. Each one is first copied into a one-entry holding stage. When the block is enabled and a tick arrives, the character moves from the holding stage into the shifter and is sent. Bit timing comes from a tick enable that runs at sixteen times the bit rate. Each frame is built from a configuration taken at the moment it starts:

- five to eight data bits, least significant first;
- an optional even or odd parity bit;
- a stop period of one, one and a half, or two bit times.

An optional line-coding mode sends data and parity bits as transitions rather than levels. The enable input only decides whether a new frame may begin. A frame already on the line always finishes, and a character waiting in the holding stage or the queue is kept until the block is enabled again.

Top module: `serial_frame_tx`

## Requirements
- R1: The line idles high. A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then a high stop period.
- R2: The data-width setting selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Character bits above the selected width are not sent.
- R3: With parity enabled, a parity bit follows the data. With the odd-select input low, the data plus parity bit hold an even number of ones; with it high, an odd number.
- R4: Every start, data and parity bit lasts 16 ticks. The stop period lasts 16, 24 or 32 ticks for stop codes 0, 1 and 2 (code 3 acts as 2).
- R5: The busy output rises on the same edge the start bit appears and falls on the edge after the last stop tick. Its high time is therefore the frame's tick count times the tick spacing.
- R6: With line coding on, each data and parity bit of value 1 toggles the line and each bit of value 0 keeps the line level. The first coded bit is taken relative to the low start bit. The start and stop levels do not change.
- R7: Pop is high, combinationally, whenever the queue is valid and the holding stage is empty. The character is captured on that edge, and pop stays low while the holding stage is full.
- R8: While enable is low, a character can still fill the holding stage, but no frame starts, the line stays high and busy stays low.
- R9: Dropping enable during a frame lets that frame complete. A character already held is kept and is sent after enable returns.
- R10: If enable is high and the holding stage is full when the stop period ends, the next start bit follows at once and busy stays high.
- R11: The frame state changes only on tick cycles, so a frame begins only on a tick.
- R12: After reset the line is high, busy is low and the holding stage is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable at sixteen times the bit rate |
| enable | input | 1 | Allows new frames to start |
| cfgDataBits | input | CFG_W | Data width code: 0 means 5 bits, up to 3 meaning 8 bits |
| cfgParityEn | input | 1 | Adds a parity bit |
| cfgParityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfgStop | input | 2 | Stop length: 0 is one bit, 1 is one and a half bits, 2 or 3 is two bits |
| cfgLineCode | input | 1 | Turns on transition coding of data and parity bits |
| qValid | input | 1 | Upstream queue has a character |
| qData | input | DATA_W | Character at the head of the queue |
| qPop | output | 1 | Holding stage takes the character this cycle |
| txLine | output | 1 | Serial output line |
| busy | output | 1 | A frame is on the line |

## Verification
Every line update happens on the first clock edge after the tick that ends the previous bit. The bench generates the tick itself, so it knows where each bit boundary falls. It starts counting on the first falling clock edge at which busy is seen high, and samples the line at the middle of every bit, half a bit time (32 cycles) after each boundary. Busy must then stay high for exactly the expected tick count times the tick spacing, and must be low with the line high one cycle later, or still high when a following frame is chained on. Pop is combinational, so the bench checks it on the falling edge before the capturing clock edge.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_t;

  // Strobes from the control to the datapath, plus the per-frame settings it needs
  typedef struct packed {
    logic loadStart;
    logic shiftData;
    logic sendParity;
    logic sendStop;
    logic parityOdd;
    logic lineCode;
  } txStrobe_t;

endpackage

// File: rtl/sftx_ctrl.sv
module sftx_ctrl
  import sftx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int MIN_DATA      = 5,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   tick,
  input  logic                                   enable,
  input  logic                                   holdValid,
  input  logic [$clog2(DATA_W-MIN_DATA+1)-1:0]   cfgDataBits,
  input  logic                                   cfgParityEn,
  input  logic                                   cfgParityOdd,
  input  logic [1:0]                             cfgStop,
  input  logic                                   cfgLineCode,
  output txStrobe_t                              strb,
  output logic                                   busy
);

  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LIM_ONE  = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] LIM_TWO  = CNT_W'(2 * TICKS_PER_BIT - 1);

  txState_t         state, nextState;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] dataLast;
  logic             parEnQ, oddQ, codeQ;
  logic [1:0]       stopQ;
  logic [CNT_W-1:0] stopLimit;
  logic [CNT_W-1:0] curLimit;
  logic             bitEnd;
  logic             startGo;

  always_comb begin
    case (stopQ)
      2'd0:    stopLimit = LIM_ONE;
      2'd1:    stopLimit = LIM_HALF;
      default: stopLimit = LIM_TWO;
    endcase
  end

  assign curLimit = (state == ST_STOP) ? stopLimit : LIM_ONE;
  assign bitEnd   = tick && (tickCnt == curLimit);
  assign startGo  = tick && enable && holdValid;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    nextState       = state;
    strb            = '0;
    strb.parityOdd  = oddQ;
    strb.lineCode   = codeQ;
    case (state)
      ST_IDLE: begin
        if (startGo) begin
          strb.loadStart = 1'b1;
          nextState      = ST_START;
        end
      end
      ST_START: begin
        if (bitEnd) begin
          strb.shiftData = 1'b1;
          nextState      = ST_DATA;
        end
      end
      ST_DATA: begin
        if (bitEnd) begin
          if (bitIdx != dataLast) begin
            strb.shiftData = 1'b1;
          end else if (parEnQ) begin
            strb.sendParity = 1'b1;
            nextState       = ST_PARITY;
          end else begin
            strb.sendStop = 1'b1;
            nextState     = ST_STOP;
          end
        end
      end
      ST_PARITY: begin
        if (bitEnd) begin
          strb.sendStop = 1'b1;
          nextState     = ST_STOP;
        end
      end
      ST_STOP: begin
        if (bitEnd) begin
          if (startGo) begin
            strb.loadStart = 1'b1;
            nextState      = ST_START;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      bitIdx   <= '0;
      dataLast <= IDX_W'(DATA_W - 1);
      parEnQ   <= 1'b0;
      oddQ     <= 1'b0;
      codeQ    <= 1'b0;
      stopQ    <= 2'd0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE || bitEnd) begin
        tickCnt <= '0;
      end else if (tick) begin
        tickCnt <= tickCnt + 1'b1;
      end
      if (strb.loadStart) begin
        bitIdx   <= '0;
        dataLast <= IDX_W'(MIN_DATA - 1) + IDX_W'(cfgDataBits);
        parEnQ   <= cfgParityEn;
        oddQ     <= cfgParityOdd;
        codeQ    <= cfgLineCode;
        stopQ    <= cfgStop;
      end else if (strb.shiftData && state == ST_DATA) begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  // R11: the frame state moves only on tick cycles
  p_step_on_tick_r11: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(state));

  // R8: an idle, disabled transmitter stays idle
  p_hold_while_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !enable) |=> (state == ST_IDLE));

endmodule

// File: rtl/sftx_datapath.sv
module sftx_datapath
  import sftx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic              qValid,
  input  logic [DATA_W-1:0] qData,
  output logic              qPop,
  output logic              holdValid,
  output logic              txLine
);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic              parAcc;
  logic              lineReg;
  logic              dataBit;
  logic              parBit;

  assign qPop    = qValid && !holdValid;
  assign dataBit = shiftReg[0];
  assign parBit  = parAcc ^ strb.parityOdd;
  assign txLine  = lineReg;

  // Holding stage between the queue and the shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdReg   <= '0;
    end else if (strb.loadStart) begin
      holdValid <= 1'b0;
    end else if (qPop) begin
      holdValid <= 1'b1;
      holdReg   <= qData;
    end
  end

  // Shifter, running parity and line level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      lineReg  <= 1'b1;
    end else if (strb.loadStart) begin
      shiftReg <= holdReg;
      parAcc   <= 1'b0;
      lineReg  <= 1'b0;
    end else if (strb.shiftData) begin
      shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
      parAcc   <= parAcc ^ dataBit;
      lineReg  <= strb.lineCode ? (lineReg ^ dataBit) : dataBit;
    end else if (strb.sendParity) begin
      lineReg <= strb.lineCode ? (lineReg ^ parBit) : parBit;
    end else if (strb.sendStop) begin
      lineReg <= 1'b1;
    end
  end

  // R7: the control only starts a frame when a character is held
  p_load_needs_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadStart |-> holdValid);

  // R7: a held character is not replaced before it is sent
  p_hold_kept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (holdValid && !strb.loadStart) |=> (holdValid && $stable(holdReg)));

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sftx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int MIN_DATA      = 5,
  parameter int TICKS_PER_BIT = 16,
  localparam int CFG_W        = $clog2(DATA_W - MIN_DATA + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              enable,
  input  logic [CFG_W-1:0]  cfgDataBits,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic [1:0]        cfgStop,
  input  logic              cfgLineCode,
  input  logic              qValid,
  input  logic [DATA_W-1:0] qData,
  output logic              qPop,
  output logic              txLine,
  output logic              busy
);

  txStrobe_t strb;
  logic      holdValid;

  sftx_ctrl #(
    .DATA_W(DATA_W),
    .MIN_DATA(MIN_DATA),
    .TICKS_PER_BIT(TICKS_PER_BIT)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .tick(tick),
    .enable(enable),
    .holdValid(holdValid),
    .cfgDataBits(cfgDataBits),
    .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd),
    .cfgStop(cfgStop),
    .cfgLineCode(cfgLineCode),
    .strb(strb),
    .busy(busy)
  );

  sftx_datapath #(
    .DATA_W(DATA_W)
  ) uData (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .qValid(qValid),
    .qData(qData),
    .qPop(qPop),
    .holdValid(holdValid),
    .txLine(txLine)
  );

  // R1: the line is high whenever no frame is in progress
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);

  // R5: busy rises together with the low start bit
  p_start_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !txLine);

endmodule

// File: tb/tb_serial_frame_tx.sv
module tb_serial_frame_tx;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CYC    = 16 * TICK_DIV;
  localparam int NVEC       = 8;

  // Vector fields: [14] line code, [13:12] stop, [11] odd, [10] parity en, [9:8] width, [7:0] data
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 1'b0, 1'b0, 2'd3, 8'h4B},
    {1'b0, 2'd2, 1'b0, 1'b1, 2'd3, 8'hA5},
    {1'b0, 2'd0, 1'b1, 1'b1, 2'd2, 8'h3C},
    {1'b0, 2'd1, 1'b0, 1'b0, 2'd0, 8'hFF},
    {1'b0, 2'd1, 1'b0, 1'b1, 2'd1, 8'h2D},
    {1'b1, 2'd0, 1'b0, 1'b0, 2'd3, 8'h4B},
    {1'b1, 2'd3, 1'b1, 1'b1, 2'd3, 8'h00},
    {1'b1, 2'd1, 1'b0, 1'b1, 2'd0, 8'h13}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       tick;
  logic       enable;
  logic [1:0] cfgDataBits;
  logic       cfgParityEn;
  logic       cfgParityOdd;
  logic [1:0] cfgStop;
  logic       cfgLineCode;
  logic       qValid;
  logic [7:0] qData;
  logic       qPop;
  logic       txLine;
  logic       busy;

  int checks = 0;
  int errors = 0;
  int tickCnt = 0;
  bit finished = 0;

  serial_frame_tx dut (
    .clk(clk), .rstN(rstN), .tick(tick), .enable(enable),
    .cfgDataBits(cfgDataBits), .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd), .cfgStop(cfgStop),
    .cfgLineCode(cfgLineCode), .qValid(qValid), .qData(qData),
    .qPop(qPop), .txLine(txLine), .busy(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tickCnt = (tickCnt == TICK_DIV - 1) ? 0 : tickCnt + 1;
      tick = (tickCnt == 0);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [14:0] plain8(input logic [7:0] d);
    return {1'b0, 2'd0, 1'b0, 1'b0, 2'd3, d};
  endfunction

  task automatic applyCfg(input logic [14:0] v);
    @(negedge clk);
    cfgLineCode  = v[14];
    cfgStop      = v[13:12];
    cfgParityOdd = v[11];
    cfgParityEn  = v[10];
    cfgDataBits  = v[9:8];
  endtask

  task automatic push(input logic [7:0] d);
    int guard = 0;
    @(negedge clk);
    qValid = 1'b1;
    qData  = d;
    #1;
    while (!qPop && guard < 20000) begin
      @(negedge clk);
      #1;
      guard++;
    end
    @(negedge clk);
    qValid = 1'b0;
  endtask

  // Receives one frame, starting at the negedge where busy is first seen high
  task automatic recvFrame(input logic [14:0] v, input bit waitRise,
                           input bit idleAfter, input string tag);
    int nb, pen, stopTicks, nFrame, expCyc, idx, guard;
    logic [11:0] expBits, gotBits;
    logic lvl, par, pb;
    bit busyBad;
    nb = 5 + int'(v[9:8]);
    pen = int'(v[10]);
    stopTicks = (v[13:12] == 2'd0) ? 16 : (v[13:12] == 2'd1) ? 24 : 32;
    nFrame = 1 + nb + pen + 1;
    expCyc = (16 * (1 + nb + pen) + stopTicks) * TICK_DIV;
    expBits = '0;
    gotBits = '0;
    lvl = 1'b0;
    par = 1'b0;
    for (int i = 0; i < nb; i++) begin
      lvl = v[14] ? (lvl ^ v[i]) : v[i];
      par = par ^ v[i];
      expBits[1 + i] = lvl;
    end
    if (pen == 1) begin
      pb = par ^ v[11];
      lvl = v[14] ? (lvl ^ pb) : pb;
      expBits[1 + nb] = lvl;
    end
    expBits[nFrame - 1] = 1'b1;
    guard = 0;
    if (waitRise) begin
      while (!busy && guard < 20000) begin
        @(negedge clk);
        guard++;
      end
    end
    busyBad = 0;
    idx = 0;
    for (int k = 0; k < expCyc; k++) begin
      if (!busy) busyBad = 1;
      if ((k % BIT_CYC) == BIT_CYC / 2 && idx < nFrame) begin
        gotBits[idx] = txLine;
        idx++;
      end
      @(negedge clk);
    end
    // R1 R2 R3 R6: the line content of the frame
    check(gotBits == expBits, "R1 R2 R3 R6", {tag, " frame bits"}, 32'(gotBits), 32'(expBits));
    // R4 R5 R11: busy spans exactly the frame's tick count
    check(!busyBad, "R4 R5 R11", {tag, " busy held"}, 32'(busyBad), 32'd0);
    if (idleAfter)
      check(!busy && txLine, "R4 R5", {tag, " idle after stop"}, {30'd0, busy, txLine}, 32'd1);
    else
      check(busy, "R10", {tag, " busy chained"}, 32'(busy), 32'd1);
  endtask

  task automatic watchIdle(input int n, input string req, input string tag, input bit popExp);
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy || !txLine || (qPop != popExp)) bad = 1;
    end
    check(!bad, req, tag, 32'(bad), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    enable = 1'b0;
    qValid = 1'b0;
    qData = '0;
    cfgDataBits = 2'd3;
    cfgParityEn = 1'b0;
    cfgParityOdd = 1'b0;
    cfgStop = 2'd0;
    cfgLineCode = 1'b0;
    repeat (5) @(negedge clk);
    // R12: reset state
    check(txLine == 1'b1, "R12", "line after reset", 32'(txLine), 32'd1);
    check(busy == 1'b0, "R12", "busy after reset", 32'(busy), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    qValid = 1'b1;
    qData = 8'h4B;
    #1;
    // R12 R7: empty holding stage pops at once
    check(qPop == 1'b1, "R12 R7", "pop with empty hold", 32'(qPop), 32'd1);
    @(negedge clk);
    #1;
    check(qPop == 1'b0, "R7", "pop while hold full", 32'(qPop), 32'd0);
    qValid = 1'b0;

    // Table of formats, walked by one loop; first character already held
    applyCfg(VEC[0]);
    enable = 1'b1;
    recvFrame(VEC[0], 1, 1, "vec0");
    for (int i = 1; i < NVEC; i++) begin
      applyCfg(VEC[i]);
      push(VEC[i][7:0]);
      recvFrame(VEC[i], 1, 1, $sformatf("vec%0d", i));
    end

    // R8: load while disabled, then R10 back-to-back after enable
    enable = 1'b0;
    applyCfg(plain8(8'h11));
    push(8'h11);
    @(negedge clk);
    qValid = 1'b1;
    qData = 8'h22;
    watchIdle(300, "R8 R7", "disabled with held data", 1'b0);
    fork
      begin
        while (!qPop) @(negedge clk);
        @(negedge clk);
        qValid = 1'b0;
      end
    join_none
    enable = 1'b1;
    recvFrame(plain8(8'h11), 1, 0, "R8 first");
    recvFrame(plain8(8'h22), 0, 1, "R10 chained");

    // R9: disable mid-frame, frame completes, held character waits
    push(8'h5A);
    fork
      push(8'h66);
      begin
        repeat (200) @(negedge clk);
        enable = 1'b0;
      end
    join_none
    recvFrame(plain8(8'h5A), 1, 1, "R9 finish");
    watchIdle(300, "R9", "no start while disabled", 1'b0);
    enable = 1'b1;
    recvFrame(plain8(8'h66), 1, 1, "R9 resume");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule